// File: doc/BRIEF.md
# Page Owner Map Lookup

Each tile in a tiled processor keeps a small, fully associative table that links a virtual page number to the tile whose first-level cache holds that page. The lookup runs in the same cycle as the local cache and translation lookups, and it uses the same virtual address. A hit that names the requesting tile lets the access continue locally. A hit that names another tile sends the access to that tile: the local cache result and the translation result, hit or miss, are dropped, and the virtual address is routed to the home tile.

A miss raises a trap for one cycle. The access then stalls until the operating-system path answers on the fill port. The fill can install an explicit owner. It can install the requester as owner, which is the first-touch default. It can also install a replicated read-only local mapping. Reads through a replicated mapping stay local. The first write through one traps, and the fill that answers it replaces that same entry, so the writer becomes the single fixed owner. A flush input empties the whole table in one cycle; it is used at barriers and lock acquires. Replacement follows least-recently-used order over the entries.

Top module: `page_owner_map`

## Requirements
- R1: After reset the table holds no valid entry and no output is active: with no request, go_local, go_remote and trap are all 0, and every access traps.
- R2: A lookup miss asserts trap for exactly one cycle. In that cycle trap_vpn equals address bits [31:12], trap_tile equals acc_tile and trap_write equals acc_write. Until a fill arrives, no access is accepted and no further trap is raised.
- R3: A hit on an owner entry whose owner equals acc_tile asserts go_local and not go_remote, for both reads and writes.
- R4: A hit on an owner entry whose owner differs from acc_tile asserts go_remote with remote_tile equal to the owner and go_local low, for both reads and writes.
- R5: fill_kind encodes the fill. 0 installs fill_owner as owner. 1 installs the trapped requester as owner (first touch). 2 installs a replicated read-only mapping. 3 acts as 0. The page installed is always the trapped page.
- R6: A read that hits a replicated mapping asserts go_local, whatever tile the entry records.
- R7: A write that hits a replicated mapping traps with trap_upgrade=1. The fill that answers it rewrites that same entry as an owner entry. After that, writes from the new owner go local and accesses from other tiles go remote to it.
- R8: A fill that arrives while no trap is pending is ignored, and the page stays unmapped.
- R9: A flush invalidates every entry in one cycle, so the access in the next cycle traps.
- R10: A flush that coincides with a fill wins: nothing is installed, the pending miss is cancelled, and the re-presented access traps again.
- R11: When all 8 entries are valid, a fill replaces the least recently used entry, and a hit counts as a use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Load or store lookup request |
| acc_vaddr | input | 32 | Virtual address of the access |
| acc_write | input | 1 | 1 for a store, 0 for a load |
| acc_tile | input | 4 | Tile ID of the requester |
| fill_valid | input | 1 | Fill response from the trap handler |
| fill_kind | input | 2 | Fill type: 0 owner, 1 first touch, 2 replica, 3 owner |
| fill_owner | input | 4 | Owner tile for owner and replica fills |
| flush | input | 1 | Invalidate all entries |
| go_local | output | 1 | Access proceeds in the local cache |
| go_remote | output | 1 | Access is routed to the home tile |
| remote_tile | output | 4 | Home tile when go_remote, else 0 |
| trap | output | 1 | One-cycle miss or upgrade trap |
| trap_vpn | output | 20 | Page number of the trapping access |
| trap_tile | output | 4 | Requester of the trapping access |
| trap_write | output | 1 | Trapping access was a store |
| trap_upgrade | output | 1 | Trap is a write to a replicated mapping |

## Verification
The assertions rely on three things about the inputs. The trap handler answers only a pending trap, and only for the trapped page. A stalled requester presents its access again after the fill, not during the wait. Only one tile ID is used at a time as the tile that can take ownership through an upgrade. The bench follows a handler model: it fills exactly once after each trap it sees, and it presents accesses again only once the fill cycle has passed. Fills and flushes that arrive at the wrong moment are issued on purpose only for R8 and R10, and in both cases the table contents are then read back through the trap and route outputs.

// File: rtl/pom_pkg.sv
package pom_pkg;
    localparam int VA_W    = 32;
    localparam int PAGE_W  = 12;
    localparam int VPN_W   = VA_W - PAGE_W;
    localparam int TILE_W  = 4;
    localparam int ENTRIES = 8;
    localparam int IDX_W   = $clog2(ENTRIES);

    typedef enum logic [1:0] {
        FILL_OWNER = 2'd0,
        FILL_FIRST = 2'd1,
        FILL_SHARE = 2'd2,
        FILL_RSVD  = 2'd3
    } fill_kind_e;

    typedef enum logic {
        ST_LOOK = 1'b0,
        ST_WAIT = 1'b1
    } pom_state_e;

    typedef struct packed {
        logic              valid;
        logic [VPN_W-1:0]  vpn;
        logic [TILE_W-1:0] owner;
        logic              shared;
    } map_ent_t;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [TILE_W-1:0] tile;
        logic              upgrade;
        logic [IDX_W-1:0]  idx;
    } pend_t;

    function automatic map_ent_t make_entry(input logic [VPN_W-1:0] vpn,
                                            input logic [1:0] kind,
                                            input logic [TILE_W-1:0] req_tile,
                                            input logic [TILE_W-1:0] owner);
        map_ent_t e;
        e.valid  = 1'b1;
        e.vpn    = vpn;
        e.owner  = (kind == FILL_FIRST) ? req_tile : owner;
        e.shared = (kind == FILL_SHARE);
        return e;
    endfunction
endpackage

// File: rtl/pom_cam.sv
module pom_cam
    import pom_pkg::*;
#(
    parameter int N  = ENTRIES,
    localparam int IW = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic [VPN_W-1:0] look_vpn,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  map_ent_t         wr_ent,
    output logic [N-1:0]     valid_vec,
    output logic             hit,
    output logic [IW-1:0]    hit_idx,
    output logic [TILE_W-1:0] hit_owner,
    output logic             hit_shared
);
    map_ent_t       tbl [N];
    logic [N-1:0]   match;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) tbl[i] <= '0;
        end else if (flush) begin
            for (int i = 0; i < N; i++) tbl[i].valid <= 1'b0;
        end else if (wr_en) begin
            tbl[wr_idx] <= wr_ent;
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_match
        assign match[g]     = tbl[g].valid && (tbl[g].vpn == look_vpn);
        assign valid_vec[g] = tbl[g].valid;
    end

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) hit_idx = hit_idx | IW'(i);
        end
    end

    assign hit        = |match;
    assign hit_owner  = tbl[hit_idx].owner;
    assign hit_shared = tbl[hit_idx].shared;

    AST_MATCH_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match));                                        // R3
    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_vec == '0));                            // R9
endmodule

// File: rtl/pom_lru.sv
module pom_lru #(
    parameter int N  = 8,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          touch_en,
    input  logic [IW-1:0] touch_idx,
    input  logic [N-1:0]  valid_vec,
    output logic [IW-1:0] victim
);
    logic [IW-1:0] age [N];
    logic [N-1:0]  seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) age[i] <= IW'(i);
        end else if (touch_en) begin
            for (int i = 0; i < N; i++) begin
                if (IW'(i) == touch_idx)
                    age[i] <= '0;
                else if (age[i] < age[touch_idx])
                    age[i] <= age[i] + 1'b1;
            end
        end
    end

    always_comb begin
        logic found;
        found  = 1'b0;
        victim = '0;
        for (int i = 0; i < N; i++) begin
            if (!found && !valid_vec[i]) begin
                victim = IW'(i);
                found  = 1'b1;
            end
        end
        if (!found) begin
            for (int i = 0; i < N; i++) begin
                if (age[i] == IW'(N - 1)) victim = IW'(i);
            end
        end
    end

    always_comb begin
        seen = '0;
        for (int i = 0; i < N; i++) seen[age[i]] = 1'b1;
    end

    AST_AGE_PERM: assert property (@(posedge clk) disable iff (rst)
        $countones(seen) == N);                                  // R11
endmodule

// File: rtl/pom_ctrl.sv
module pom_ctrl
    import pom_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [TILE_W-1:0] acc_tile,
    input  logic [VPN_W-1:0]  acc_vpn,
    input  logic              hit,
    input  logic [IDX_W-1:0]  hit_idx,
    input  logic [TILE_W-1:0] hit_owner,
    input  logic              hit_shared,
    input  logic              fill_valid,
    input  logic [1:0]        fill_kind,
    input  logic [TILE_W-1:0] fill_owner,
    input  logic              flush,
    input  logic [IDX_W-1:0]  victim,
    output logic              go_local,
    output logic              go_remote,
    output logic [TILE_W-1:0] remote_tile,
    output logic              trap,
    output logic              trap_write,
    output logic              trap_upgrade,
    output logic              touch_en,
    output logic [IDX_W-1:0]  touch_idx,
    output logic              ins_en,
    output logic [IDX_W-1:0]  ins_idx,
    output map_ent_t          ins_ent
);
    pom_state_e st;
    pend_t      pend;
    logic       look, upg, accept;

    always_comb begin
        look         = (st == ST_LOOK) && acc_valid && !flush;
        upg          = hit && hit_shared && acc_write;
        accept       = look && hit && !upg;
        go_local     = accept && (hit_shared || (hit_owner == acc_tile));
        go_remote    = accept && !(hit_shared || (hit_owner == acc_tile));
        remote_tile  = go_remote ? hit_owner : '0;
        trap         = look && (!hit || upg);
        trap_write   = trap && acc_write;
        trap_upgrade = trap && upg;
        ins_en       = (st == ST_WAIT) && fill_valid && !flush;
        ins_idx      = pend.upgrade ? pend.idx : victim;
        ins_ent      = make_entry(pend.vpn, fill_kind, pend.tile, fill_owner);
        touch_en     = accept || ins_en;
        touch_idx    = accept ? hit_idx : ins_idx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_LOOK;
            pend <= '0;
        end else if (flush) begin
            st <= ST_LOOK;
        end else begin
            case (st)
                ST_LOOK: if (trap) begin
                    st           <= ST_WAIT;
                    pend.vpn     <= acc_vpn;
                    pend.tile    <= acc_tile;
                    pend.upgrade <= upg;
                    pend.idx     <= hit_idx;
                end
                ST_WAIT: if (fill_valid) st <= ST_LOOK;
                default: st <= ST_LOOK;
            endcase
        end
    end

    AST_TRAP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        trap |=> !trap);                                         // R2
    AST_STALL_AFTER_TRAP: assert property (@(posedge clk) disable iff (rst)
        trap |=> !(go_local || go_remote));                      // R2
    AST_REMOTE_NOT_SELF: assert property (@(posedge clk) disable iff (rst)
        go_remote |-> (remote_tile != acc_tile));                // R4
    AST_FLUSH_WINS: assert property (@(posedge clk) disable iff (rst)
        (flush && fill_valid) |=> (st == ST_LOOK));              // R10
endmodule

// File: rtl/page_owner_map.sv
module page_owner_map
    import pom_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [VA_W-1:0]   acc_vaddr,
    input  logic              acc_write,
    input  logic [TILE_W-1:0] acc_tile,
    input  logic              fill_valid,
    input  logic [1:0]        fill_kind,
    input  logic [TILE_W-1:0] fill_owner,
    input  logic              flush,
    output logic              go_local,
    output logic              go_remote,
    output logic [TILE_W-1:0] remote_tile,
    output logic              trap,
    output logic [VPN_W-1:0]  trap_vpn,
    output logic [TILE_W-1:0] trap_tile,
    output logic              trap_write,
    output logic              trap_upgrade
);
    logic [VPN_W-1:0]   acc_vpn;
    logic               page_off_unused;
    logic [ENTRIES-1:0] valid_vec;
    logic               hit, hit_shared;
    logic [IDX_W-1:0]   hit_idx, victim, touch_idx, ins_idx;
    logic [TILE_W-1:0]  hit_owner;
    logic               touch_en, ins_en;
    map_ent_t           ins_ent;

    assign acc_vpn         = acc_vaddr[VA_W-1:PAGE_W];
    assign page_off_unused = ^acc_vaddr[PAGE_W-1:0];
    assign trap_vpn        = acc_vpn;
    assign trap_tile       = acc_tile;

    pom_cam #(.N(ENTRIES)) i_cam (
        .clk(clk), .rst(rst), .flush(flush), .look_vpn(acc_vpn),
        .wr_en(ins_en), .wr_idx(ins_idx), .wr_ent(ins_ent),
        .valid_vec(valid_vec), .hit(hit), .hit_idx(hit_idx),
        .hit_owner(hit_owner), .hit_shared(hit_shared)
    );

    pom_lru #(.N(ENTRIES)) i_lru (
        .clk(clk), .rst(rst), .touch_en(touch_en), .touch_idx(touch_idx),
        .valid_vec(valid_vec), .victim(victim)
    );

    pom_ctrl i_ctrl (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_tile(acc_tile), .acc_vpn(acc_vpn), .hit(hit), .hit_idx(hit_idx),
        .hit_owner(hit_owner), .hit_shared(hit_shared),
        .fill_valid(fill_valid), .fill_kind(fill_kind), .fill_owner(fill_owner),
        .flush(flush), .victim(victim), .go_local(go_local),
        .go_remote(go_remote), .remote_tile(remote_tile), .trap(trap),
        .trap_write(trap_write), .trap_upgrade(trap_upgrade),
        .touch_en(touch_en), .touch_idx(touch_idx), .ins_en(ins_en),
        .ins_idx(ins_idx), .ins_ent(ins_ent)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> !(go_local || go_remote || (valid_vec != '0)));  // R1
endmodule

// File: tb/test_page_owner_map.sv
`timescale 1ns/1ps
module test_page_owner_map;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_vaddr = '0;
    logic        acc_write = 1'b0;
    logic [3:0]  acc_tile = '0;
    logic        fill_valid = 1'b0;
    logic [1:0]  fill_kind = '0;
    logic [3:0]  fill_owner = '0;
    logic        flush = 1'b0;
    logic        go_local, go_remote, trap, trap_write, trap_upgrade;
    logic [3:0]  remote_tile, trap_tile;
    logic [19:0] trap_vpn;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    int s_loc, s_rem, s_rt, s_trap, s_tvpn, s_ttile, s_twr, s_tup;

    always #2 clk = ~clk;

    page_owner_map i_page_owner_map (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_vaddr(acc_vaddr),
        .acc_write(acc_write), .acc_tile(acc_tile), .fill_valid(fill_valid),
        .fill_kind(fill_kind), .fill_owner(fill_owner), .flush(flush),
        .go_local(go_local), .go_remote(go_remote), .remote_tile(remote_tile),
        .trap(trap), .trap_vpn(trap_vpn), .trap_tile(trap_tile),
        .trap_write(trap_write), .trap_upgrade(trap_upgrade)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic access(input int vpn, input bit wr, input int tile);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_vaddr = {vpn[19:0], 12'h5a5};
        acc_write = wr;
        acc_tile  = tile[3:0];
        #1;
        s_loc = go_local; s_rem = go_remote; s_rt = remote_tile;
        s_trap = trap; s_tvpn = trap_vpn; s_ttile = trap_tile;
        s_twr = trap_write; s_tup = trap_upgrade;
        @(posedge clk);
        #1;
        acc_valid = 1'b0;
    endtask

    task automatic fill(input int kind, input int owner, input bit fl);
        @(negedge clk);
        fill_valid = 1'b1;
        fill_kind  = kind[1:0];
        fill_owner = owner[3:0];
        flush      = fl;
        @(posedge clk);
        #1;
        fill_valid = 1'b0;
        flush      = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(posedge clk);
        #1;
        flush = 1'b0;
    endtask

    task automatic expect_route(input string req, input int vpn, input bit wr,
                                input int tile, input int owner);
        access(vpn, wr, tile);
        chk(req, "trap", s_trap, 0);
        chk(req, "go_local", s_loc, (owner == tile) ? 1 : 0);
        chk(req, "go_remote", s_rem, (owner == tile) ? 0 : 1);
        chk(req, "remote_tile", s_rt, (owner == tile) ? 0 : owner);
    endtask

    task automatic expect_trap(input string req, input int vpn, input bit wr,
                               input int tile, input bit upg);
        access(vpn, wr, tile);
        chk(req, "trap", s_trap, 1);
        chk(req, "go_local", s_loc, 0);
        chk(req, "go_remote", s_rem, 0);
        chk(req, "trap_vpn", s_tvpn, vpn);
        chk(req, "trap_tile", s_ttile, tile);
        chk(req, "trap_write", s_twr, wr);
        chk(req, "trap_upgrade", s_tup, upg);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #1;
        // R1: quiet outputs with no request, empty table
        chk("R1", "go_local idle", go_local, 0);
        chk("R1", "go_remote idle", go_remote, 0);
        chk("R1", "trap idle", trap, 0);
        expect_trap("R1", 5, 1'b0, 1, 1'b0);
        fill(0, 1, 1'b1);

        // R2/R3/R4/R5: sweep eight pages from tile 1
        for (int p = 0; p < 8; p++) begin
            int kind;
            int own;
            kind = (p % 3 == 0) ? 1 : ((p == 7) ? 3 : 0);
            own  = (p % 3 == 0) ? 1 : (p % 4);
            expect_trap("R2", p, p[0], 1, 1'b0);
            access(p, p[0], 1);
            chk("R2", "no retrap while waiting", s_trap, 0);
            chk("R2", "stalled while waiting", s_loc + s_rem, 0);
            fill(kind, p % 4, 1'b0);
            expect_route((own == 1) ? "R3" : "R4", p, 1'b0, 1, own);
            expect_route((kind == 1) ? "R5" : "R4", p, 1'b1, 1, own);
        end

        // R11: page 0 touched, so page 1 is the oldest when page 100 arrives
        expect_route("R11", 0, 1'b0, 1, 1);
        expect_trap("R11", 100, 1'b0, 1, 1'b0);
        fill(0, 3, 1'b0);
        expect_route("R11", 100, 1'b0, 1, 3);
        expect_route("R11", 0, 1'b0, 1, 1);
        expect_route("R11", 2, 1'b0, 1, 2);
        expect_trap("R11", 1, 1'b0, 1, 1'b0);

        // R10: flush beats the fill that answers the pending miss
        fill(1, 0, 1'b1);
        expect_trap("R10", 1, 1'b0, 1, 1'b0);
        fill(0, 2, 1'b0);
        expect_route("R10", 1, 1'b0, 1, 2);

        // R9: the flush above emptied the table
        expect_trap("R9", 0, 1'b0, 1, 1'b0);
        fill(2, 3, 1'b0);

        // R6/R7: replicated mapping, then write upgrade
        expect_route("R6", 0, 1'b0, 1, 1);
        expect_route("R6", 0, 1'b0, 2, 2);
        expect_trap("R7", 0, 1'b1, 1, 1'b1);
        fill(1, 0, 1'b0);
        expect_route("R7", 0, 1'b1, 1, 1);
        expect_route("R7", 0, 1'b1, 2, 1);
        expect_route("R7", 0, 1'b0, 2, 1);
        expect_route("R7", 1, 1'b0, 1, 2);

        // R8: fill with no pending trap is dropped
        fill(1, 0, 1'b0);
        expect_trap("R8", 50, 1'b0, 1, 1'b0);
        fill(0, 0, 1'b0);
        expect_route("R8", 50, 1'b0, 1, 0);

        // R9: single-cycle flush, next cycle misses
        do_flush();
        expect_trap("R9", 50, 1'b1, 1, 1'b0);
        fill(0, 6, 1'b0);
        expect_route("R9", 50, 1'b1, 1, 6);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule